// File: doc/BRIEF.md
# Bunch-Synchronous Peak-Window Energy Filter

This block turns a stream of raw, unsigned calorimeter ADC samples into one signed energy word for each trigger tick. The beam repeats in a cycle of three ticks with four samples per tick, so twelve samples make up a cycle. Of each cycle the block keeps five consecutive samples around the pulse peak, weights them with signed programmable coefficients and adds them up. No decimating stage sits in front of the sum. Samples outside the window are dropped as they arrive.

Ticks still run at the full rate, so the downstream latency does not change. Each tick strobe yields exactly one output word one clock later. On the crossing tick that word carries the measurement. On the other two ticks it carries a programmable zero-energy code.

Three measurement modes are available:
- **Filter mode** reports the saturated weighted sum.
- **Difference mode** reports the change from the previous crossing, which cancels slow baseline drift.
- **Raw mode** bypasses the filter for commissioning and reports the single window sample nearest the peak.

Top module: `bx_energy_filter`

## Requirements
- R1: After reset `energyValid` is low and `energyOut` is zero until the first tick strobe.
- R2: Every `tickStrobe` produces exactly one `energyValid` pulse on the next clock. `energyValid` is never high at any other time.
- R3: On ticks whose index differs from `bxTick`, `energyOut` equals `zeroCode`. A `bxTick` of 3 matches no tick, so all three ticks carry `zeroCode`.
- R4: Only samples with in-cycle index `winStart` through `winStart+4` change the filter result. All other samples are ignored.
- R5: In filter mode (`mode` 1 or 3), the crossing tick reports the sum over k = 0..4 of coef[k] × (k-th window sample). coef[k] is the signed value in `coefVec[8k+7:8k]`. The result used is the latest window completed before the tick strobe.
- R6: Filter and difference outputs saturate to the range -32768 to +32767.
- R7: In difference mode (`mode` 2), the crossing tick reports the current filter result minus the result stored at the previous crossing, saturated.
- R8: The first crossing in difference mode after reset or after any change of `mode` outputs `zeroCode`, and it stores the current result as the reference.
- R9: In raw mode (`mode` 0), the crossing tick reports the window sample at offset 2 (index `winStart+2`), zero-extended.
- R10: `cycleMark` together with `sampleValid` makes that sample index 0. `cycleMark` together with `tickStrobe` makes that tick index 0. Otherwise, sample indices count 0..11 and tick indices count 0..2, each wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One ADC sample accepted this clock |
| sampleData | input | 10 | Unsigned ADC sample |
| tickStrobe | input | 1 | One trigger tick; requests one output word |
| cycleMark | input | 1 | Cycle-phase marker; realigns sample or tick index to 0 |
| mode | input | 2 | 0 raw, 1 filter, 2 difference, 3 filter |
| winStart | input | 3 | First sample index of the five-sample window |
| bxTick | input | 2 | Tick index (0..2) that holds the crossing |
| coefVec | input | 40 | Five signed 8-bit coefficients, coef[k] at bits 8k+7:8k |
| zeroCode | input | 16 | Code sent on ticks without a crossing |
| energyValid | output | 1 | Output word valid |
| energyOut | output | 16 | Energy word for the tick |

## Verification
The bench places the window at both extremes (start 0 and start 7). It drives changing junk values outside the window, so a design that miscounts indices or lets outside samples into the sum shows a changed result. Full-scale positive and negative sums check that the output clamps rather than wraps: a design that only truncates would give a small or sign-flipped word. Difference mode is exercised across a change of mode and back, so a design that keeps a stale reference would output a real difference instead of the zero code. A mid-stream realignment with `cycleMark` confirms that the crossing lands on the marked phase and not on a free-running count.

// File: rtl/bxef_pkg.sv
package bxef_pkg;

  typedef enum logic [1:0] {
    MODE_RAW  = 2'd0,
    MODE_FILT = 2'd1,
    MODE_DIFF = 2'd2,
    MODE_ALT  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_RAW  = 2'd1,
    SEL_FILT = 2'd2,
    SEL_DIFF = 2'd3
  } outSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       take;      // sample belongs to the window
    logic [2:0] tap;       // window offset of that sample
    logic       first;     // first window sample: restart sum
    logic       last;      // last window sample: latch result
    logic       rawTake;   // centre sample for raw mode
    logic       emit;      // produce an output word
    outSel_e    outSel;    // what the word carries
    logic       loadPrev;  // store result as difference reference
  } ctl_t;

endpackage

// File: rtl/bxef_ctrl.sv
module bxef_ctrl
  import bxef_pkg::*;
#(
  parameter int SAMPLES_PER_CYCLE = 12,
  parameter int TICKS_PER_CYCLE   = 3,
  parameter int TAPS              = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleValid,
  input  logic       tickStrobe,
  input  logic       cycleMark,
  input  logic [1:0] mode,
  input  logic [$clog2(SAMPLES_PER_CYCLE-TAPS+1)-1:0] winStart,
  input  logic [1:0] bxTick,
  output ctl_t       ctl
);

  localparam int IDX_W   = $clog2(SAMPLES_PER_CYCLE);
  localparam int TICK_W  = $clog2(TICKS_PER_CYCLE);
  localparam int START_W = $clog2(SAMPLES_PER_CYCLE-TAPS+1);

  logic [IDX_W-1:0]  sampleIdx, idxCur;
  logic [TICK_W-1:0] tickCnt, tickCur;
  logic [IDX_W:0]    offset;
  logic              inWin, bxHit, havePrev;
  logic [1:0]        modeQ;

  assign idxCur  = (sampleValid && cycleMark) ? '0 : sampleIdx;
  assign tickCur = (tickStrobe && cycleMark) ? '0 : tickCnt;
  assign offset  = {1'b0, idxCur} - (IDX_W+1)'(winStart);
  assign inWin   = ({1'b0, idxCur} >= (IDX_W+1)'(winStart)) && (offset < (IDX_W+1)'(TAPS));
  assign bxHit   = ({{(8-TICK_W){1'b0}}, tickCur} == {6'd0, bxTick});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleIdx <= '0;
      tickCnt   <= '0;
      modeQ     <= '0;
      havePrev  <= 1'b0;
    end else begin
      modeQ <= mode;
      if (sampleValid)
        sampleIdx <= (idxCur == IDX_W'(SAMPLES_PER_CYCLE-1)) ? '0 : idxCur + 1'b1;
      if (tickStrobe)
        tickCnt <= (tickCur == TICK_W'(TICKS_PER_CYCLE-1)) ? '0 : tickCur + 1'b1;
      if (mode != modeQ)
        havePrev <= 1'b0;
      else if (ctl.loadPrev)
        havePrev <= 1'b1;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.take     = sampleValid && inWin;
    ctl.tap      = offset[2:0];
    ctl.first    = ctl.take && (offset == '0);
    ctl.last     = ctl.take && (offset == (IDX_W+1)'(TAPS-1));
    ctl.rawTake  = ctl.take && (offset == (IDX_W+1)'(TAPS/2));
    ctl.emit     = tickStrobe;
    ctl.outSel   = SEL_ZERO;
    ctl.loadPrev = tickStrobe && bxHit && (mode_e'(mode) == MODE_DIFF);
    if (bxHit) begin
      case (mode_e'(mode))
        MODE_RAW:  ctl.outSel = SEL_RAW;
        MODE_DIFF: ctl.outSel = havePrev ? SEL_DIFF : SEL_ZERO;
        default:   ctl.outSel = SEL_FILT;
      endcase
    end
  end

  // R10
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleIdx < IDX_W'(SAMPLES_PER_CYCLE));

  // R10
  tick_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < TICK_W'(TICKS_PER_CYCLE));

  // R8
  ref_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode != modeQ) |=> !havePrev);

  initial begin
    assert (START_W <= IDX_W) else $error("window start wider than index");
  end

endmodule

// File: rtl/bxef_dp.sv
module bxef_dp
  import bxef_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int COEF_W   = 8,
  parameter int TAPS     = 5,
  parameter int ACC_W    = 21,
  parameter int OUT_W    = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctl_t                     ctl,
  input  logic [SAMPLE_W-1:0]      sampleData,
  input  logic [TAPS*COEF_W-1:0]   coefVec,
  input  logic [OUT_W-1:0]         zeroCode,
  output logic                     energyValid,
  output logic [OUT_W-1:0]         energyOut
);

  localparam int PROD_W = COEF_W + SAMPLE_W + 1;
  localparam logic signed [ACC_W:0]   SAT_HI  = (ACC_W+1)'((1 << (OUT_W-1)) - 1);
  localparam logic signed [ACC_W:0]   SAT_LO  = -SAT_HI - 1;
  localparam logic signed [ACC_W-1:0] FILT_HI = ACC_W'((1 << (OUT_W-1)) - 1);

  logic signed [COEF_W-1:0]  coefSel;
  logic signed [PROD_W-1:0]  prod;
  logic signed [ACC_W-1:0]   acc, sumNext, result, prevRes;
  logic signed [ACC_W:0]     diffVal;
  logic [SAMPLE_W-1:0]       rawQ;
  logic [OUT_W-1:0]          outMux;

  function automatic logic [OUT_W-1:0] satOut(input logic signed [ACC_W:0] v);
    if (v > SAT_HI)      return SAT_HI[OUT_W-1:0];
    else if (v < SAT_LO) return SAT_LO[OUT_W-1:0];
    else                 return v[OUT_W-1:0];
  endfunction

  assign coefSel = coefVec[ctl.tap*COEF_W +: COEF_W];
  assign prod    = coefSel * $signed({1'b0, sampleData});
  assign sumNext = (ctl.first ? '0 : acc) + ACC_W'(prod);
  assign diffVal = {result[ACC_W-1], result} - {prevRes[ACC_W-1], prevRes};

  always_comb begin
    case (ctl.outSel)
      SEL_RAW:  outMux = OUT_W'(rawQ);
      SEL_FILT: outMux = satOut({result[ACC_W-1], result});
      SEL_DIFF: outMux = satOut(diffVal);
      default:  outMux = zeroCode;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      result      <= '0;
      prevRes     <= '0;
      rawQ        <= '0;
      energyValid <= 1'b0;
      energyOut   <= '0;
    end else begin
      if (ctl.take)     acc     <= sumNext;
      if (ctl.last)     result  <= sumNext;
      if (ctl.rawTake)  rawQ    <= sampleData;
      if (ctl.loadPrev) prevRes <= result;
      energyValid <= ctl.emit;
      if (ctl.emit)     energyOut <= outMux;
    end
  end

  // R3
  zero_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (energyValid && $past(ctl.outSel == SEL_ZERO)) |-> (energyOut == $past(zeroCode)));

  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (energyValid && $past(ctl.outSel == SEL_FILT) && ($past(result) > FILT_HI))
      |-> (energyOut == SAT_HI[OUT_W-1:0]));

endmodule

// File: rtl/bx_energy_filter.sv
module bx_energy_filter
  import bxef_pkg::*;
#(
  parameter int SAMPLE_W          = 10,
  parameter int COEF_W            = 8,
  parameter int TAPS              = 5,
  parameter int ACC_W             = 21,
  parameter int OUT_W             = 16,
  parameter int SAMPLES_PER_CYCLE = 12,
  parameter int TICKS_PER_CYCLE   = 3,
  localparam int START_W          = $clog2(SAMPLES_PER_CYCLE-TAPS+1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic [SAMPLE_W-1:0]     sampleData,
  input  logic                    tickStrobe,
  input  logic                    cycleMark,
  input  logic [1:0]              mode,
  input  logic [START_W-1:0]      winStart,
  input  logic [1:0]              bxTick,
  input  logic [TAPS*COEF_W-1:0]  coefVec,
  input  logic [OUT_W-1:0]        zeroCode,
  output logic                    energyValid,
  output logic [OUT_W-1:0]        energyOut
);

  ctl_t ctl;

  bxef_ctrl #(
    .SAMPLES_PER_CYCLE(SAMPLES_PER_CYCLE),
    .TICKS_PER_CYCLE(TICKS_PER_CYCLE),
    .TAPS(TAPS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .tickStrobe(tickStrobe),
    .cycleMark(cycleMark), .mode(mode), .winStart(winStart), .bxTick(bxTick),
    .ctl(ctl)
  );

  bxef_dp #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .TAPS(TAPS), .ACC_W(ACC_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleData(sampleData), .coefVec(coefVec),
    .zeroCode(zeroCode), .energyValid(energyValid), .energyOut(energyOut)
  );

  // R2
  tick_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickStrobe |=> energyValid);

  // R2
  valid_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    energyValid |-> $past(tickStrobe));

endmodule

// File: tb/bx_energy_filter_bench.sv
module bx_energy_filter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [9:0]  sampleData = '0;
  logic        tickStrobe = 1'b0;
  logic        cycleMark = 1'b0;
  logic [1:0]  mode = 2'd1;
  logic [2:0]  winStart = 3'd3;
  logic [1:0]  bxTick = 2'd2;
  logic [39:0] coefVec = '0;
  logic [15:0] zeroCode = '0;
  logic        energyValid;
  logic [15:0] energyOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int coef[5];
  int mIdx = 0, mTick = 0, mAcc = 0, mRes = 0, mRaw = 0, mPrev = 0;
  bit mHave = 0;
  int curMode = 1;

  always #2 clk = ~clk;

  bx_energy_filter u_bx_energy_filter (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .tickStrobe(tickStrobe), .cycleMark(cycleMark), .mode(mode), .winStart(winStart),
    .bxTick(bxTick), .coefVec(coefVec), .zeroCode(zeroCode),
    .energyValid(energyValid), .energyOut(energyOut)
  );

  function automatic int sat16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setCoefs(input int c0, input int c1, input int c2, input int c3, input int c4);
    coef[0] = c0; coef[1] = c1; coef[2] = c2; coef[3] = c3; coef[4] = c4;
    @(negedge clk);
    for (int k = 0; k < 5; k++) coefVec[8*k +: 8] = 8'(coef[k]);
  endtask

  task automatic setMode(input int m);
    @(negedge clk);
    mode = 2'(m);
    if (m != curMode) mHave = 0;
    curMode = m;
    @(negedge clk);
  endtask

  task automatic sendSample(input int val, input bit mark);
    int cur;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData  = 10'(val);
    cycleMark   = mark;
    cur = mark ? 0 : mIdx;
    if (cur >= int'(winStart) && cur < int'(winStart) + 5) begin
      int k = cur - int'(winStart);
      mAcc = (k == 0 ? 0 : mAcc) + coef[k] * val;
      if (k == 4) mRes = mAcc;
      if (k == 2) mRaw = val;
    end
    mIdx = (cur == 11) ? 0 : cur + 1;
    @(negedge clk);
    sampleValid = 1'b0;
    cycleMark   = 1'b0;
  endtask

  task automatic sendTick(input bit mark, input string tag);
    int curT, exp;
    string t;
    curT = mark ? 0 : mTick;
    t = tag;
    if (curT != int'(bxTick)) begin
      exp = int'(zeroCode);
      t = "R3";
    end else if (curMode == 0) exp = mRaw;
    else if (curMode == 2) begin
      if (!mHave) begin exp = int'(zeroCode); t = "R8"; end
      else exp = sat16(mRes - mPrev);
      mPrev = mRes;
      mHave = 1;
    end else exp = sat16(mRes);
    mTick = (curT == 2) ? 0 : curT + 1;
    @(negedge clk);
    tickStrobe = 1'b1;
    cycleMark  = mark;
    @(negedge clk);
    tickStrobe = 1'b0;
    cycleMark  = 1'b0;
    check("R2 valid", energyValid === 1'b1, int'(energyValid), 1);
    check(t, energyOut === 16'(exp), int'($signed(energyOut)), exp);
    @(negedge clk);
    check("R2 single", energyValid === 1'b0, int'(energyValid), 0);
  endtask

  // window samples: base + step*k, outside: junk
  task automatic runCycle(input int base, input int step, input int junk, input bit mark, input string tag);
    for (int t = 0; t < 3; t++) begin
      for (int s = 0; s < 4; s++) begin
        int i = t*4 + s;
        int w = int'(winStart);
        int v = (i >= w && i < w + 5) ? ((base + step*(i-w)) & 1023) : junk;
        sendSample(v, mark && i == 0);
      end
      sendTick(mark && t == 0, tag);
    end
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    check("R1 valid", energyValid === 1'b0, int'(energyValid), 0);
    check("R1 out", energyOut === 16'd0, int'(energyOut), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle", energyValid === 1'b0, int'(energyValid), 0);
  endtask

  task automatic testFilter();
    setCoefs(1, 2, 4, 2, 1);
    setMode(1);
    runCycle(100, 20, 900, 1'b1, "R5 basic");
    setCoefs(-3, 5, 7, -2, 1);
    runCycle(400, -50, 13, 1'b0, "R5 signed");
  endtask

  task automatic testZeroCode();
    zeroCode = 16'h0ABC;
    bxTick = 2'd0;
    runCycle(300, 11, 700, 1'b0, "R5 bx0");
    bxTick = 2'd3;
    runCycle(300, 11, 700, 1'b0, "R3 none");
    bxTick = 2'd2;
  endtask

  task automatic testWindow();
    setCoefs(1, 1, 1, 1, 1);
    winStart = 3'd0;
    runCycle(10, 1, 1000, 1'b0, "R4 start0");
    runCycle(10, 1, 5, 1'b0, "R4 start0 junk");
    winStart = 3'd7;
    runCycle(50, 3, 999, 1'b0, "R4 start7");
    runCycle(50, 3, 0, 1'b0, "R4 start7 junk");
    winStart = 3'd3;
  endtask

  task automatic testSaturation();
    setCoefs(127, 127, 127, 127, 127);
    runCycle(1023, 0, 0, 1'b0, "R6 high");
    setCoefs(-128, -128, -128, -128, -128);
    runCycle(1023, 0, 0, 1'b0, "R6 low");
  endtask

  task automatic testDiff();
    setCoefs(10, 20, 30, 20, 10);
    setMode(2);
    runCycle(200, 5, 600, 1'b0, "R7");
    runCycle(260, 5, 100, 1'b0, "R7 rise");
    runCycle(150, 0, 100, 1'b0, "R7 fall");
    setCoefs(127, 127, 127, 127, 127);
    runCycle(1023, 0, 0, 1'b0, "R6 diff");
    setMode(1);
    setMode(2);
    runCycle(500, 1, 0, 1'b0, "R8 rearm");
    runCycle(510, 1, 0, 1'b0, "R7 after");
  endtask

  task automatic testRaw();
    setMode(0);
    runCycle(77, 40, 1000, 1'b0, "R9");
    winStart = 3'd6;
    runCycle(600, 9, 3, 1'b0, "R9 start6");
    winStart = 3'd3;
  endtask

  task automatic testRealign();
    setMode(1);
    setCoefs(2, 3, 4, 3, 2);
    for (int s = 0; s < 5; s++) sendSample(900 + s, 1'b0);
    sendTick(1'b0, "R10 pre");
    runCycle(120, 15, 800, 1'b1, "R10");
    runCycle(220, 15, 800, 1'b0, "R10 follow");
  endtask

  initial begin
    testReset();
    testFilter();
    testZeroCode();
    testWindow();
    testSaturation();
    testDiff();
    testRaw();
    testRealign();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule